// File: doc/BRIEF.md
# Signed Saturating Vector Narrowing Unit

This block takes two wide vector operands of signed integers and narrows every element to half its width, clamping values that do not fit into the largest or smallest value of the narrower type. It narrows either 16-bit elements to 8 bits or 32-bit elements to 16 bits. The vector is split into independent 128-bit lanes. In each lane the narrowed elements of the first operand form the lower half and the narrowed elements of the second operand form the upper half.

The operation covers three vector lengths (128, 256 and 512 bits) and a per-element write mask that either keeps the prior destination value or clears the element. In halfword-output mode, one 32-bit scalar of the second operand can be broadcast to all of its positions. A compatibility mode keeps the destination bits above the first lane unchanged. Each output element also has a flag that reports whether it was clamped.

Operations enter through a valid/ready stream port and leave through another, with one register stage between them. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A result that is offered with `out_valid` but not taken with `out_ready` stays unchanged until it is taken. The control pins (`mode`, `vl_sel`, `legacy`, `mask_en`, `merge`, `bcast`, `mask`) are sampled together with the data on the accepting edge.

Top module: `vpack_sat_unit`

## Requirements
- R1: With `mode`=0 (16→8), each signed 16-bit input maps as follows. A value above +127 gives 0x7F. A value below -128 gives 0x80. Any other value gives its low byte.
- R2: With `mode`=1 (32→16), each signed 32-bit input maps as follows. A value above 32767 gives 0x7FFF. A value below -32768 gives 0x8000. Any other value gives its low halfword.
- R3: Within each 128-bit lane, the narrowed elements of `src1` fill bits 63:0 in ascending element order and the narrowed elements of `src2` fill bits 127:64. Each lane uses only the same lane of both operands.
- R4: `vl_sel` 0, 1 and 2 select 128, 256 and 512 bits (code 3 also selects 512). Every result bit at or above the selected length is 0.
- R5: When `mask_en`=1, output element j is written only if `mask[j]` is 1, where j counts bytes in mode 0 and halfwords in mode 1. An element whose mask bit is 0 takes its value from `old_dst` when `merge`=1, or becomes 0 when `merge`=0.
- R6: When `mask_en`=0, every element inside the vector length is written whatever `mask` holds. Mask bits at or above the active element count (16/32/64 in mode 0, 8/16/32 in mode 1) have no effect.
- R7: When `mode`=1 and `bcast`=1, `src2[31:0]` replaces every 32-bit element of `src2` before narrowing. In mode 0, `bcast` has no effect.
- R8: When `legacy`=1, result bits 511:128 equal `old_dst[511:128]`, the length is taken as 128 bits and masking is off, whatever `vl_sel` and `mask_en` hold.
- R9: `out_sat[j]` is 1 exactly when output element j (same numbering as R5) lies inside the vector length and was clamped. All other bits of `out_sat` are 0.
- R10: `out_valid` rises on the clock edge after an accepted operation. While `out_valid`=1 and `out_ready`=0, the result and flags hold. Synchronous active-high `rst` clears `out_valid`. Results leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| mode | input | 1 | 0: 16→8 narrowing, 1: 32→16 narrowing |
| vl_sel | input | 2 | Vector length code (0:128, 1:256, 2/3:512) |
| legacy | input | 1 | Keep destination bits above 128, fixed 128-bit length, no masking |
| mask_en | input | 1 | Enable per-element write mask |
| merge | input | 1 | 1: masked-off elements keep old value, 0: cleared |
| bcast | input | 1 | Broadcast `src2[31:0]` (mode 1 only) |
| mask | input | 64 | Per-element write mask |
| src1 | input | 512 | First operand |
| src2 | input | 512 | Second operand |
| old_dst | input | 512 | Prior destination value |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumed |
| out_data | output | 512 | Narrowed, masked result |
| out_sat | output | 64 | Per-element clamp flags |

## Verification
The only state is the output register and its valid bit. A fault in that state shows at the ports on the very next edge as one of three things: a dropped or duplicated result, a result that changes while it is being held back, or data from a different operation. The scoreboard catches each of these as an order or value mismatch. A mistake in the lane routing or in the mask expansion affects specific byte positions. It is visible in the first result that uses that lane, mode or mask bit, so the directed cases target each lane, each mode and the boundary values ±128, ±32768 and their neighbours.

// File: rtl/pk_pkg.sv
package pk_pkg;
  typedef enum logic {
    PK_W2B = 1'b0,
    PK_D2W = 1'b1
  } pk_mode_e;

  typedef enum logic [1:0] {
    PK_VL128 = 2'd0,
    PK_VL256 = 2'd1,
    PK_VL512 = 2'd2,
    PK_VLMAX = 2'd3
  } pk_vl_e;
endpackage

// File: rtl/pk_narrow.sv
// Clamps one signed element of IN_W bits into OUT_W bits.
module pk_narrow #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout,
  output logic             clamped
);
  localparam int HI_W = IN_W - OUT_W + 1;

  logic [HI_W-1:0] hi;
  logic            fits;

  // Fits when every bit from the output sign bit upward is identical.
  assign hi      = din[IN_W-1:OUT_W-1];
  assign fits    = (&hi) | ~(|hi);
  assign clamped = ~fits;
  assign dout    = fits ? din[OUT_W-1:0]
                        : {din[IN_W-1], {(OUT_W-1){~din[IN_W-1]}}};

  always_comb begin
    // R1/R2: a value that passes through must sign-extend back to the input
    if (!clamped) begin
      p_pass_exact_r1: assert ({{(IN_W-OUT_W){dout[OUT_W-1]}}, dout} == din);
    end
    // R2: a clamped value keeps the sign of the input
    if (clamped) begin
      p_clamp_sign_r2: assert (dout[OUT_W-1] == din[IN_W-1]);
    end
  end
endmodule

// File: rtl/pk_lane.sv
// One 128-bit lane: narrowing for both widths, src1 to the low half, src2 to the high half.
module pk_lane #(
  parameter int LANE_W = 128
) (
  input  logic [LANE_W-1:0]    s1,
  input  logic [LANE_W-1:0]    s2,
  output logic [LANE_W-1:0]    byte_res,
  output logic [LANE_W/8-1:0]  byte_sat,
  output logic [LANE_W-1:0]    half_res,
  output logic [LANE_W/16-1:0] half_sat
);
  localparam int NB  = LANE_W / 8;
  localparam int NH  = LANE_W / 16;
  localparam int NBH = NB / 2;
  localparam int NHH = NH / 2;

  for (genvar k = 0; k < NB; k++) begin : g_b
    logic [15:0] w;
    if (k < NBH) begin : g_lo
      assign w = s1[k*16 +: 16];
    end else begin : g_hi
      assign w = s2[(k-NBH)*16 +: 16];
    end
    pk_narrow #(.IN_W(16), .OUT_W(8)) u_nb (
      .din(w), .dout(byte_res[k*8 +: 8]), .clamped(byte_sat[k]));
  end

  for (genvar k = 0; k < NH; k++) begin : g_h
    logic [31:0] d;
    if (k < NHH) begin : g_lo
      assign d = s1[k*32 +: 32];
    end else begin : g_hi
      assign d = s2[(k-NHH)*32 +: 32];
    end
    pk_narrow #(.IN_W(32), .OUT_W(16)) u_nh (
      .din(d), .dout(half_res[k*16 +: 16]), .clamped(half_sat[k]));
  end
endmodule

// File: rtl/pk_wb.sv
// Byte-granular writeback: length cut, mask merge/zero, compatibility upper bits.
module pk_wb #(
  parameter int LANES  = 4,
  parameter int LANE_W = 128
) (
  input  logic [LANES*LANE_W-1:0]   packed_res,
  input  logic [LANES*LANE_W-1:0]   old_dst,
  input  logic [LANES-1:0]          lane_on,
  input  logic                      byte_mode,
  input  logic                      mask_en,
  input  logic                      merge,
  input  logic                      legacy,
  input  logic [LANES*LANE_W/8-1:0] mask,
  output logic [LANES*LANE_W-1:0]   res
);
  localparam int NBYTES  = LANES * LANE_W / 8;
  localparam int NB_LANE = LANE_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int L = b / NB_LANE;
    logic mbit;
    logic wr;
    assign mbit = byte_mode ? mask[b] : mask[b/2];
    assign wr   = ~mask_en | legacy | mbit;
    assign res[b*8 +: 8] =
        !lane_on[L] ? (legacy ? old_dst[b*8 +: 8] : 8'h00) :
        wr          ? packed_res[b*8 +: 8] :
        merge       ? old_dst[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/vpack_sat_unit.sv
module vpack_sat_unit
  import pk_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 128
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      mode,
  input  logic [1:0]                vl_sel,
  input  logic                      legacy,
  input  logic                      mask_en,
  input  logic                      merge,
  input  logic                      bcast,
  input  logic [LANES*LANE_W/8-1:0] mask,
  input  logic [LANES*LANE_W-1:0]   src1,
  input  logic [LANES*LANE_W-1:0]   src2,
  input  logic [LANES*LANE_W-1:0]   old_dst,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*LANE_W-1:0]   out_data,
  output logic [LANES*LANE_W/8-1:0] out_sat
);
  localparam int DATA_W  = LANES * LANE_W;
  localparam int NBYTES  = DATA_W / 8;
  localparam int NHALF   = DATA_W / 16;
  localparam int NDW     = DATA_W / 32;
  localparam int NB_LANE = LANE_W / 8;
  localparam int NH_LANE = LANE_W / 16;

  logic              d2w;
  logic [LANES-1:0]  lane_on;
  logic [DATA_W-1:0] src2_eff;
  logic [DATA_W-1:0] packed_res;
  logic [DATA_W-1:0] wb_res;
  logic [NBYTES-1:0] sat_b;
  logic [NHALF-1:0]  sat_h;
  logic [NBYTES-1:0] sat_d;
  logic              acc;

  assign d2w = (mode == PK_D2W);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (legacy || vl_sel == PK_VL128) lane_on[l] = (l == 0);
      else if (vl_sel == PK_VL256)      lane_on[l] = (l < 2);
      else                              lane_on[l] = 1'b1;
    end
  end

  assign src2_eff = (d2w && bcast) ? {NDW{src2[31:0]}} : src2;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0]  br;
    logic [LANE_W-1:0]  hr;
    logic [NB_LANE-1:0] bs;
    logic [NH_LANE-1:0] hs;
    pk_lane #(.LANE_W(LANE_W)) u_lane (
      .s1(src1[l*LANE_W +: LANE_W]), .s2(src2_eff[l*LANE_W +: LANE_W]),
      .byte_res(br), .byte_sat(bs), .half_res(hr), .half_sat(hs));
    assign packed_res[l*LANE_W +: LANE_W] = d2w ? hr : br;
    assign sat_b[l*NB_LANE +: NB_LANE] = lane_on[l] ? bs : '0;
    assign sat_h[l*NH_LANE +: NH_LANE] = lane_on[l] ? hs : '0;
  end

  assign sat_d = d2w ? {{(NBYTES-NHALF){1'b0}}, sat_h} : sat_b;

  pk_wb #(.LANES(LANES), .LANE_W(LANE_W)) u_wb (
    .packed_res(packed_res), .old_dst(old_dst), .lane_on(lane_on),
    .byte_mode(~d2w), .mask_en(mask_en), .merge(merge), .legacy(legacy),
    .mask(mask), .res(wb_res));

  assign in_ready = ~out_valid | out_ready;
  assign acc      = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= '0;
    end else begin
      if (acc) begin
        out_valid <= 1'b1;
        out_data  <= wb_res;
        out_sat   <= sat_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10: accepted operation appears one edge later
  p_accept_lat_r10: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);
  // R10: back-pressured result holds
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sat)));
  // R4: 128-bit length clears everything above the first lane
  p_len_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && !legacy && vl_sel == PK_VL128) |=> (out_data[DATA_W-1:LANE_W] == '0));
  // R8: compatibility mode carries the old upper bits
  p_legacy_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && legacy) |=> (out_data[DATA_W-1:LANE_W] == $past(old_dst[DATA_W-1:LANE_W])));
  // R5: zeroing mask clears byte element 0 when its bit is low
  p_zero_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && mask_en && !merge && !legacy && !d2w && !mask[0]) |=> (out_data[7:0] == 8'h00));
endmodule

// File: tb/vpack_sat_unit_tb_top.sv
module vpack_sat_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         mode = 1'b0;
  logic [1:0]   vl_sel = 2'd0;
  logic         legacy = 1'b0;
  logic         mask_en = 1'b0;
  logic         merge = 1'b0;
  logic         bcast = 1'b0;
  logic [63:0]  mask = '0;
  logic [511:0] src1 = '0;
  logic [511:0] src2 = '0;
  logic [511:0] old_dst = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [511:0] out_data;
  logic [63:0]  out_sat;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [511:0] data;
    logic [63:0]  sat;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  vpack_sat_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .vl_sel(vl_sel), .legacy(legacy), .mask_en(mask_en),
    .merge(merge), .bcast(bcast), .mask(mask), .src1(src1), .src2(src2),
    .old_dst(old_dst), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sat(out_sat));

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference built from the requirement text
  function automatic void model(input logic [511:0] a, input logic [511:0] b,
                                input logic [511:0] od, input logic md,
                                input logic [1:0] vl, input logic men,
                                input logic mg, input logic bc, input logic lg,
                                input logic [63:0] mk,
                                output logic [511:0] d, output logic [63:0] s);
    int lanes;
    int v;
    int l;
    logic [511:0] bb;
    logic [511:0] pk;
    logic [15:0] w;
    logic [31:0] dw;
    bit en;
    lanes = lg ? 1 : (vl == 2'd0 ? 1 : (vl == 2'd1 ? 2 : 4));
    bb = b;
    if (md && bc) for (int i = 0; i < 16; i++) bb[i*32 +: 32] = b[31:0];
    pk = '0;
    s = '0;
    for (int ln = 0; ln < 4; ln++) begin
      if (!md) begin
        for (int k = 0; k < 16; k++) begin
          w = (k < 8) ? a[ln*128 + k*16 +: 16] : bb[ln*128 + (k-8)*16 +: 16];
          v = int'($signed(w));
          if (v > 127) pk[ln*128 + k*8 +: 8] = 8'h7F;
          else if (v < -128) pk[ln*128 + k*8 +: 8] = 8'h80;
          else pk[ln*128 + k*8 +: 8] = w[7:0];
          s[ln*16 + k] = (ln < lanes) && (v > 127 || v < -128);
        end
      end else begin
        for (int k = 0; k < 8; k++) begin
          dw = (k < 4) ? a[ln*128 + k*32 +: 32] : bb[ln*128 + (k-4)*32 +: 32];
          v = $signed(dw);
          if (v > 32767) pk[ln*128 + k*16 +: 16] = 16'h7FFF;
          else if (v < -32768) pk[ln*128 + k*16 +: 16] = 16'h8000;
          else pk[ln*128 + k*16 +: 16] = dw[15:0];
          s[ln*8 + k] = (ln < lanes) && (v > 32767 || v < -32768);
        end
      end
    end
    for (int bt = 0; bt < 64; bt++) begin
      l = bt / 16;
      en = md ? mk[bt/2] : mk[bt];
      if (l >= lanes) d[bt*8 +: 8] = lg ? od[bt*8 +: 8] : 8'h00;
      else if (!men || lg || en) d[bt*8 +: 8] = pk[bt*8 +: 8];
      else d[bt*8 +: 8] = mg ? od[bt*8 +: 8] : 8'h00;
    end
  endfunction

  // Driver: called just after a falling edge
  task automatic send(input logic [511:0] a, input logic [511:0] b,
                      input logic [511:0] od, input logic md, input logic [1:0] vl,
                      input logic men, input logic mg, input logic bc,
                      input logic lg, input logic [63:0] mk, input string tag);
    exp_t e;
    src1 = a; src2 = b; old_dst = od; mode = md; vl_sel = vl; mask_en = men;
    merge = mg; bcast = bc; legacy = lg; mask = mk; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    model(a, b, od, md, vl, men, mg, bc, lg, mk, e.data, e.sat);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: a result offered with out_ready high is consumed at the next edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10 unexpected result", out_data, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(out_data === e.data, e.tag, out_data, e.data);
          chk(out_sat === e.sat, {"R9 flags ", e.tag}, {448'd0, out_sat}, {448'd0, e.sat});
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_on ? 1'($urandom % 2) : 1'b1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] w_pat(int i);
    case (i % 8)
      0: return 16'h0100;  1: return 16'hFF00;
      2: return 16'h007F;  3: return 16'hFF80;
      4: return 16'h0080;  5: return 16'hFF7F;
      6: return 16'h0005;  default: return 16'hFFFB;
    endcase
  endfunction

  function automatic logic [31:0] d_pat(int i);
    case (i % 8)
      0: return 32'h00008000;  1: return 32'hFFFF7FFF;
      2: return 32'h00007FFF;  3: return 32'hFFFF8000;
      4: return 32'h12345678;  5: return 32'h80000000;
      6: return 32'h00000042;  default: return 32'hFFFFFFF0;
    endcase
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  logic [511:0] a_w, b_w, a_d, b_d, a_lane, b_lane, ones;

  initial begin
    ones = '1;
    for (int i = 0; i < 32; i++) begin
      a_w[i*16 +: 16] = w_pat(i);
      b_w[i*16 +: 16] = w_pat(i + 3);
      a_lane[i*16 +: 16] = 16'(i);
      b_lane[i*16 +: 16] = 16'(16'hFFC0 + i);
    end
    for (int i = 0; i < 16; i++) begin
      a_d[i*32 +: 32] = d_pat(i);
      b_d[i*32 +: 32] = d_pat(i + 5);
    end

    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R10 reset out_valid", {511'd0, out_valid}, '0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(in_ready === 1'b1, "R10 ready after reset", {511'd0, in_ready}, 512'd1);
    @(negedge clk);

    // R10 latency: valid one edge after acceptance, then low again
    send(a_w, b_w, '0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1 byte clamp vl128");
    #1;
    chk(out_valid === 1'b1, "R10 valid after one edge", {511'd0, out_valid}, 512'd1);
    @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R10 valid drops", {511'd0, out_valid}, '0);
    @(negedge clk);

    send(a_d, b_d, '0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 half clamp vl512");
    send(a_lane, b_lane, '0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 lane order byte");
    send(a_lane, b_lane, '0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 lane order half");
    send(a_d, b_d, ones, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R4 vl256 upper zero");
    send(a_w, b_w, ones, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R4 vl128 upper zero");
    send(a_w, b_w, ones, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0,
         64'hA5A5_0F0F_3C3C_5555, "R5 merge byte");
    send(a_d, b_d, ones, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0,
         64'h0000_0000_C3A5_9966, "R5 zero half");
    send(a_w, b_w, ones, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R6 mask off writes all");
    send(a_w, b_w, ones, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0,
         64'hFFFF_FFFF_FFFF_00FF, "R6 byte mask upper ignored");
    send(a_d, b_d, ones, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0,
         64'hFFFF_FFFF_FFFF_FF0F, "R6 half mask upper ignored");
    send(a_d, b_d, '0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R7 broadcast half");
    send(a_w, b_w, '0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R7 broadcast ignored byte");
    send(a_w, b_w, ones, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, '0, "R8 legacy byte");
    send(a_d, b_d, rnd512(), 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, '0, "R8 legacy half");

    // R10 back-pressure with random operations
    bp_on = 1'b1;
    for (int n = 0; n < 60; n++) begin
      send(rnd512(), rnd512(), rnd512(), 1'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0,
           {$urandom, $urandom}, "R10 random stream under back-pressure");
    end
    bp_on = 1'b0;
    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R10 all results delivered", 512'(sb.size()), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule